// File: doc/BRIEF.md
# Deblocking Fetch Window Sequencer

This block sits in front of an in-loop deblocking filter that works one macroblock at a time on a 352×288 frame of 4:2:0 video. Given the column and row of a macroblock and a start pulse, it sorts that macroblock into one of four position classes. The class depends on whether a neighbour exists above it, to its left, both or neither. From the class it builds the rectangle of samples the filter needs, for the luma plane and for each of the two chroma planes.

The block then streams one address per cycle. Each beat carries a frame-store address and the matching offset inside a per-plane local buffer. The first pass is the read pass, which copies frame data into the local buffers. A second pass over the same addresses follows for the write-back of the filtered samples. Issuing the memory transactions and running the filter belong to the surrounding logic.

Where a neighbour exists, the window reaches 4 samples past the macroblock on that side (above and/or left) in every plane. This lets the shared edge be filtered together with the current macroblock.

Top module: `dbw_fetch_window`

## Requirements
- R1: `cls` takes the value {top neighbour present, left neighbour present}. This gives 0 for column 0 / row 0, 1 for row 0 with column > 0, 2 for column 0 with row > 0, and 3 otherwise. It is valid from the cycle after the start is taken.
- R2: The luma window is 16 wide plus 4 when a left neighbour exists, and 16 tall plus 4 when a top neighbour exists. Each chroma window is 8 wide/tall plus 4 under the same conditions.
- R3: The window's upper-left sample is at (16·col − 4·left, 16·row − 4·top) in luma and (8·col − 4·left, 8·row − 4·top) in chroma.
- R4: Beats come on consecutive cycles. The read pass (`out_wr`=0) comes first, then the write-back pass (`out_wr`=1). Within a pass the planes come in the order luma (`out_plane`=0), U (1), V (2). Within a plane the order is row by row from the top, and each row runs left to right.
- R5: `out_fs_addr` is base + (y0+r)·stride + x0 + c. Luma uses base 0 and stride 352. U uses base 101376 and stride 176. V uses base 126720 and stride 176.
- R6: `out_lb_addr` is r·width + c, so it restarts at 0 for each plane of each pass.
- R7: `out_last` is high only on the final V-plane beat of the write-back pass.
- R8: A start pulse while `busy` is high is ignored. The class, window sizes and stream of the job in progress are unchanged.
- R9: During and after reset, `busy`, `out_vld` and `out_last` are low.
- R10: When a start is taken at clock edge k, `busy` is high after edge k and the first beat is valid after edge k+1. A job produces 2·(luma area + 2·chroma area) beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a job for the given macroblock |
| mb_x | input | 5 | Macroblock column (0..21) |
| mb_y | input | 5 | Macroblock row (0..17) |
| busy | output | 1 | Address scan in progress |
| cls | output | 2 | Position class |
| lum_w | output | 5 | Luma window width |
| lum_h | output | 5 | Luma window height |
| chr_w | output | 5 | Chroma window width |
| chr_h | output | 5 | Chroma window height |
| out_vld | output | 1 | Address beat valid |
| out_wr | output | 1 | 0 read pass, 1 write-back pass |
| out_plane | output | 2 | 0 luma, 1 U, 2 V |
| out_fs_addr | output | 18 | Frame-store sample address |
| out_lb_addr | output | 9 | Local-buffer offset in that plane |
| out_last | output | 1 | Final beat of the job |

## Verification
The bench drives one macroblock of each class: the picture's corner, the interior of the first row, the interior of the first column, and two inner positions, one of them the bottom-right macroblock. The first row and first column patterns separate width growth from height growth, so a swapped width and height or a swapped origin offset shows up at once. The bottom-right position exercises the highest frame addresses in all three planes. A start issued in the cycle that `busy` falls tests back-to-back acceptance, and a stray start in mid-job must leave both the class and the beat stream untouched.

// File: rtl/dbw_pkg.sv
package dbw_pkg;
  typedef enum logic [1:0] {
    CLS_CORNER  = 2'd0,
    CLS_TOPROW  = 2'd1,
    CLS_LEFTCOL = 2'd2,
    CLS_INNER   = 2'd3
  } mb_class_e;

  typedef enum logic [1:0] {
    PL_Y = 2'd0,
    PL_U = 2'd1,
    PL_V = 2'd2
  } plane_e;
endpackage

// File: rtl/dbw_classify.sv
// Latches class, window sizes and window origins when a job is taken.
module dbw_classify #(
  parameter int MB_COLS = 22,
  parameter int MB_ROWS = 18,
  parameter int MB      = 16,
  parameter int CMB     = 8,
  parameter int EXT     = 4,
  parameter int EXT_C   = 4,
  localparam int MXW = $clog2(MB_COLS),
  localparam int MYW = $clog2(MB_ROWS),
  localparam int DW  = $clog2(MB + EXT + 1),
  localparam int XW  = $clog2(MB_COLS * MB),
  localparam int YW  = $clog2(MB_ROWS * MB)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load,
  input  logic [MXW-1:0]         mb_x,
  input  logic [MYW-1:0]         mb_y,
  output dbw_pkg::mb_class_e     cls,
  output logic [DW-1:0]          lum_w,
  output logic [DW-1:0]          lum_h,
  output logic [DW-1:0]          chr_w,
  output logic [DW-1:0]          chr_h,
  output logic [XW-1:0]          lx0,
  output logic [YW-1:0]          ly0,
  output logic [XW-1:0]          cx0,
  output logic [YW-1:0]          cy0
);
  logic has_left, has_top;
  assign has_left = (mb_x != '0);
  assign has_top  = (mb_y != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cls   <= dbw_pkg::CLS_CORNER;
      lum_w <= DW'(MB);
      lum_h <= DW'(MB);
      chr_w <= DW'(CMB);
      chr_h <= DW'(CMB);
      lx0   <= '0;
      ly0   <= '0;
      cx0   <= '0;
      cy0   <= '0;
    end else if (load) begin
      cls   <= dbw_pkg::mb_class_e'({has_top, has_left});
      lum_w <= DW'(MB  + (has_left ? EXT   : 0));
      lum_h <= DW'(MB  + (has_top  ? EXT   : 0));
      chr_w <= DW'(CMB + (has_left ? EXT_C : 0));
      chr_h <= DW'(CMB + (has_top  ? EXT_C : 0));
      lx0   <= XW'(32'(mb_x) * MB  - (has_left ? EXT   : 0));
      ly0   <= YW'(32'(mb_y) * MB  - (has_top  ? EXT   : 0));
      cx0   <= XW'(32'(mb_x) * CMB - (has_left ? EXT_C : 0));
      cy0   <= YW'(32'(mb_y) * CMB - (has_top  ? EXT_C : 0));
    end
  end
endmodule

// File: rtl/dbw_scan.sv
// Walks pass / plane / row / column, one position per cycle.
module dbw_scan #(
  parameter int DW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DW-1:0]     lum_w,
  input  logic [DW-1:0]     lum_h,
  input  logic [DW-1:0]     chr_w,
  input  logic [DW-1:0]     chr_h,
  output logic              active,
  output logic              wr,
  output dbw_pkg::plane_e   plane,
  output logic [DW-1:0]     row,
  output logic [DW-1:0]     col,
  output logic [DW-1:0]     cur_w,
  output logic              final_pos
);
  import dbw_pkg::*;
  logic [DW-1:0] cur_h;
  logic          row_end, col_end;

  assign cur_w     = (plane == PL_Y) ? lum_w : chr_w;
  assign cur_h     = (plane == PL_Y) ? lum_h : chr_h;
  assign col_end   = (col == cur_w - 1'b1);
  assign row_end   = (row == cur_h - 1'b1);
  assign final_pos = active && wr && (plane == PL_V) && row_end && col_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      wr     <= 1'b0;
      plane  <= PL_Y;
      row    <= '0;
      col    <= '0;
    end else if (load) begin
      active <= 1'b1;
      wr     <= 1'b0;
      plane  <= PL_Y;
      row    <= '0;
      col    <= '0;
    end else if (active) begin
      if (!col_end) begin
        col <= col + 1'b1;
      end else begin
        col <= '0;
        if (!row_end) begin
          row <= row + 1'b1;
        end else begin
          row <= '0;
          if (plane != PL_V) begin
            plane <= plane_e'(plane + 2'd1);
          end else begin
            plane <= PL_Y;
            if (wr) active <= 1'b0;
            else    wr     <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/dbw_addr.sv
// Turns a scan position into registered frame-store and local-buffer addresses.
module dbw_addr #(
  parameter int MB_COLS = 22,
  parameter int MB_ROWS = 18,
  parameter int MB      = 16,
  parameter int CMB     = 8,
  parameter int DW      = 5,
  parameter int XW      = 9,
  parameter int YW      = 9,
  parameter int AW      = 18,
  parameter int LW      = 9,
  localparam int LSTRIDE = MB_COLS * MB,
  localparam int CSTRIDE = MB_COLS * CMB,
  localparam int LSIZE   = LSTRIDE * MB_ROWS * MB,
  localparam int CSIZE   = CSTRIDE * MB_ROWS * CMB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic              in_wr,
  input  dbw_pkg::plane_e   in_plane,
  input  logic [DW-1:0]     row,
  input  logic [DW-1:0]     col,
  input  logic [DW-1:0]     width,
  input  logic              in_last,
  input  logic [XW-1:0]     lx0,
  input  logic [YW-1:0]     ly0,
  input  logic [XW-1:0]     cx0,
  input  logic [YW-1:0]     cy0,
  output logic              out_vld,
  output logic              out_wr,
  output logic [1:0]        out_plane,
  output logic [AW-1:0]     out_fs,
  output logic [LW-1:0]     out_lb,
  output logic              out_last
);
  import dbw_pkg::*;
  int base, stride, x0, y0;

  always_comb begin
    case (in_plane)
      PL_U:    begin base = LSIZE;         stride = CSTRIDE; end
      PL_V:    begin base = LSIZE + CSIZE; stride = CSTRIDE; end
      default: begin base = 0;             stride = LSTRIDE; end
    endcase
    x0 = (in_plane == PL_Y) ? int'(lx0) : int'(cx0);
    y0 = (in_plane == PL_Y) ? int'(ly0) : int'(cy0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld   <= 1'b0;
      out_wr    <= 1'b0;
      out_plane <= '0;
      out_fs    <= '0;
      out_lb    <= '0;
      out_last  <= 1'b0;
    end else begin
      out_vld   <= in_vld;
      out_wr    <= in_wr;
      out_plane <= in_plane;
      out_fs    <= AW'(base + (y0 + int'(row)) * stride + x0 + int'(col));
      out_lb    <= LW'(int'(row) * int'(width) + int'(col));
      out_last  <= in_last;
    end
  end
endmodule

// File: rtl/dbw_fetch_window.sv
module dbw_fetch_window #(
  parameter int MB_COLS = 22,
  parameter int MB_ROWS = 18,
  parameter int MB      = 16,
  parameter int CMB     = 8,
  parameter int EXT     = 4,
  parameter int EXT_C   = 4,
  localparam int MXW = $clog2(MB_COLS),
  localparam int MYW = $clog2(MB_ROWS),
  localparam int DW  = $clog2(MB + EXT + 1),
  localparam int XW  = $clog2(MB_COLS * MB),
  localparam int YW  = $clog2(MB_ROWS * MB),
  localparam int AW  = $clog2(MB_COLS * MB * MB_ROWS * MB * 3 / 2),
  localparam int LW  = $clog2((MB + EXT) * (MB + EXT))
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [MXW-1:0] mb_x,
  input  logic [MYW-1:0] mb_y,
  output logic           busy,
  output logic [1:0]     cls,
  output logic [DW-1:0]  lum_w,
  output logic [DW-1:0]  lum_h,
  output logic [DW-1:0]  chr_w,
  output logic [DW-1:0]  chr_h,
  output logic           out_vld,
  output logic           out_wr,
  output logic [1:0]     out_plane,
  output logic [AW-1:0]  out_fs_addr,
  output logic [LW-1:0]  out_lb_addr,
  output logic           out_last
);
  import dbw_pkg::*;
  mb_class_e     cls_e;
  logic          load, active, s_wr, s_final;
  plane_e        s_plane;
  logic [DW-1:0] s_row, s_col, s_w;
  logic [XW-1:0] lx0, cx0;
  logic [YW-1:0] ly0, cy0;

  assign load = start && !active;
  assign busy = active;
  assign cls  = cls_e;

  dbw_classify #(.MB_COLS(MB_COLS), .MB_ROWS(MB_ROWS), .MB(MB), .CMB(CMB),
                 .EXT(EXT), .EXT_C(EXT_C)) u_cls (
    .clk(clk), .rst(rst), .load(load), .mb_x(mb_x), .mb_y(mb_y),
    .cls(cls_e), .lum_w(lum_w), .lum_h(lum_h), .chr_w(chr_w), .chr_h(chr_h),
    .lx0(lx0), .ly0(ly0), .cx0(cx0), .cy0(cy0)
  );

  dbw_scan #(.DW(DW)) u_scan (
    .clk(clk), .rst(rst), .load(load),
    .lum_w(lum_w), .lum_h(lum_h), .chr_w(chr_w), .chr_h(chr_h),
    .active(active), .wr(s_wr), .plane(s_plane), .row(s_row), .col(s_col),
    .cur_w(s_w), .final_pos(s_final)
  );

  dbw_addr #(.MB_COLS(MB_COLS), .MB_ROWS(MB_ROWS), .MB(MB), .CMB(CMB),
             .DW(DW), .XW(XW), .YW(YW), .AW(AW), .LW(LW)) u_addr (
    .clk(clk), .rst(rst), .in_vld(active), .in_wr(s_wr), .in_plane(s_plane),
    .row(s_row), .col(s_col), .width(s_w), .in_last(s_final),
    .lx0(lx0), .ly0(ly0), .cx0(cx0), .cy0(cy0),
    .out_vld(out_vld), .out_wr(out_wr), .out_plane(out_plane),
    .out_fs(out_fs_addr), .out_lb(out_lb_addr), .out_last(out_last)
  );
endmodule

// File: rtl/dbw_fetch_window_chk.sv
module dbw_fetch_window_chk #(
  parameter int MB_COLS = 22,
  parameter int MB_ROWS = 18,
  parameter int MB      = 16,
  parameter int AW      = 18,
  parameter int LW      = 9
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic [1:0]    cls,
  input logic          out_vld,
  input logic          out_wr,
  input logic [1:0]    out_plane,
  input logic [AW-1:0] out_fs_addr,
  input logic [LW-1:0] out_lb_addr,
  input logic          out_last
);
  localparam int LSIZE = MB_COLS * MB * MB_ROWS * MB;

  p_reset_idle_r9: assert property (@(posedge clk)
    rst |=> (!out_vld && !busy && !out_last));

  p_last_tail_r7: assert property (@(posedge clk) disable iff (rst)
    out_last |-> (out_vld && out_wr && out_plane == 2'd2));

  p_beats_contig_r4: assert property (@(posedge clk) disable iff (rst)
    (out_vld && !out_last) |=> out_vld);

  p_lb_step_r6: assert property (@(posedge clk) disable iff (rst)
    (out_vld && $past(out_vld) && !$past(out_last) &&
     out_plane == $past(out_plane) && out_wr == $past(out_wr))
    |-> (out_lb_addr == $past(out_lb_addr) + 1'b1));

  p_lb_restart_r6: assert property (@(posedge clk) disable iff (rst)
    (out_vld && $past(out_vld) &&
     (out_plane != $past(out_plane) || out_wr != $past(out_wr)))
    |-> (out_lb_addr == '0));

  p_luma_range_r5: assert property (@(posedge clk) disable iff (rst)
    (out_vld && out_plane == 2'd0) |-> (int'(out_fs_addr) < LSIZE));

  p_cls_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(cls));
endmodule

bind dbw_fetch_window dbw_fetch_window_chk #(
  .MB_COLS(MB_COLS), .MB_ROWS(MB_ROWS), .MB(MB), .AW(AW), .LW(LW)
) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .cls(cls), .out_vld(out_vld),
  .out_wr(out_wr), .out_plane(out_plane), .out_fs_addr(out_fs_addr),
  .out_lb_addr(out_lb_addr), .out_last(out_last)
);

// File: tb/dbw_fetch_window_test.sv
module dbw_fetch_window_test;
  typedef struct packed {
    logic        wr;
    logic [1:0]  pl;
    logic [17:0] fs;
    logic [8:0]  lb;
    logic        last;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [4:0] mb_x = '0, mb_y = '0;
  logic busy, out_vld, out_wr, out_last;
  logic [1:0] cls, out_plane;
  logic [4:0] lum_w, lum_h, chr_w, chr_h;
  logic [17:0] out_fs_addr;
  logic [8:0] out_lb_addr;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  item_t exp_q[$];

  always #4 clk = ~clk;

  dbw_fetch_window uut (
    .clk(clk), .rst(rst), .start(start), .mb_x(mb_x), .mb_y(mb_y),
    .busy(busy), .cls(cls), .lum_w(lum_w), .lum_h(lum_h), .chr_w(chr_w),
    .chr_h(chr_h), .out_vld(out_vld), .out_wr(out_wr), .out_plane(out_plane),
    .out_fs_addr(out_fs_addr), .out_lb_addr(out_lb_addr), .out_last(out_last)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Monitor: pops expected beats and compares (R4, R5, R6, R7)
  always @(negedge clk) begin
    if (!rst && out_vld) begin
      item_t got, e;
      got = '{out_wr, out_plane, out_fs_addr, out_lb_addr, out_last};
      if (exp_q.size() == 0) begin
        check(1'b0, "R4", "unexpected beat fs", int'(out_fs_addr), -1);
      end else begin
        e = exp_q.pop_front();
        check(got == e, "R4/R5/R6/R7", "beat {wr,pl,fs,lb,last}",
              int'(got), int'(e));
      end
    end
  end

  // Driver: pushes expected beats, starts a job, checks class/sizes/latency
  task automatic run_mb(input int x, input int y, input bit stray);
    int top, left, lw, lh, cw, ch, n0;
    top = (y != 0); left = (x != 0);
    lw = 16 + 4*left; lh = 16 + 4*top;
    cw = 8 + 4*left;  ch = 8 + 4*top;
    while (busy) @(negedge clk);
    n0 = exp_q.size();
    for (int p = 0; p < 2; p++)
      for (int pl = 0; pl < 3; pl++) begin
        int w, h, bs, st, ox, oy;
        w  = (pl == 0) ? lw : cw;
        h  = (pl == 0) ? lh : ch;
        bs = (pl == 0) ? 0 : (pl == 1 ? 101376 : 126720);
        st = (pl == 0) ? 352 : 176;
        ox = (pl == 0) ? 16*x - 4*left : 8*x - 4*left;
        oy = (pl == 0) ? 16*y - 4*top  : 8*y - 4*top;
        for (int r = 0; r < h; r++)
          for (int c = 0; c < w; c++) begin
            item_t it;
            it.wr = p[0]; it.pl = pl[1:0];
            it.fs = 18'(bs + (oy + r)*st + ox + c);
            it.lb = 9'(r*w + c);
            it.last = (p == 1 && pl == 2 && r == h-1 && c == w-1);
            exp_q.push_back(it);
          end
      end
    check(exp_q.size() - n0 == 2*(lw*lh + 2*cw*ch), "R10", "beat count",
          exp_q.size() - n0, 2*(lw*lh + 2*cw*ch));
    mb_x = 5'(x); mb_y = 5'(y); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R10", "busy after start", busy, 1);
    check(out_vld == 1'b0, "R10", "no beat one edge after start", out_vld, 0);
    check(cls == 2'(top*2 + left), "R1", "class", cls, top*2 + left);
    check(lum_w == 5'(lw) && lum_h == 5'(lh), "R2", "luma w*32+h",
          lum_w*32 + lum_h, lw*32 + lh);
    check(chr_w == 5'(cw) && chr_h == 5'(ch), "R2", "chroma w*32+h",
          chr_w*32 + chr_h, cw*32 + ch);
    @(negedge clk);
    check(out_vld == 1'b1, "R10", "first beat two edges after start", out_vld, 1);
    if (stray) begin
      repeat (20) @(negedge clk);
      mb_x = 5'(x == 0 ? 3 : 0); mb_y = 5'(y == 0 ? 3 : 0); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      check(cls == 2'(top*2 + left), "R8", "class after stray start",
            cls, top*2 + left);
      check(lum_w == 5'(lw) && lum_h == 5'(lh), "R8", "luma size after stray",
            lum_w*32 + lum_h, lw*32 + lh);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !out_vld && !out_last, "R9", "idle in reset",
          {busy, out_vld, out_last}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !out_vld, "R9", "idle after reset", {busy, out_vld}, 0);
    run_mb(0, 0, 1'b0);    // R1 corner class, R3 origin at 0
    run_mb(5, 0, 1'b1);    // top row, R3 left extension, R8 stray start
    run_mb(0, 7, 1'b0);    // first column, R3 top extension
    run_mb(21, 17, 1'b1);  // inner, highest addresses (R5)
    run_mb(10, 9, 1'b0);   // inner, taken the cycle busy falls
    while (busy || exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(!out_vld && exp_q.size() == 0, "R7", "stream ends after last beat",
          out_vld, 0);
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end
endmodule